// File: doc/BRIEF.md
# SPI Clock-Register Access Slave

This block is the serial front end of a real-time-clock macro. A host talks to it over a four-wire serial link in mode 0 (clock idles low, data sampled on the rising clock edge, eight-bit words, most significant bit first). The chip-select line, active low, frames each transaction. The first byte of a frame is an instruction and the second is a starting register address. The bytes that follow are either streamed into consecutive clock registers or streamed out of them.

Toward the timekeeping and alarm logic the block has a plain register-bus port. It drives an address, write data and a one-cycle write strobe, and it takes back a read-data byte that the register file supplies combinationally for the current address. Only two instructions touch the clock registers. Every other instruction byte is swallowed, together with the rest of its frame, and has no effect on the bus or on the serial output. All serial inputs are oversampled by the system clock through synchronisers, so the whole block runs in one clock domain.

Top module: `spi_rtc_slave`

## Requirements
- R1: While chip select is high, and out of reset, `miso` is 0 and `regWe` stays low.
- R2: Instruction byte 0x13 followed by an address byte starts a read. On every following byte slot the register at the current address is shifted out on `miso`, most significant bit first, and each bit is valid before the host's rising edge.
- R3: Instruction byte 0x12 followed by an address byte starts a write. Each complete data byte yields exactly one `regWe` pulse, with `regWdata` equal to that byte, while chip select is still low.
- R4: The address advances by one after every data byte, whether read or written. From the last implemented register (`LAST_ADDR`, default 0x1F) or any higher address it moves to 0x00.
- R5: The instruction bytes 0x01, 0x02, 0x03, 0x04, 0x05, 0x06, 0x14, 0x32, 0x33, 0x44 and 0x54, like any value other than 0x12 and 0x13, cause no write strobe for the rest of the frame and leave `miso` at 0.
- R6: Raising chip select aborts the frame and clears the bit count. A data byte cut short by that release is discarded, and the next frame begins with an instruction byte.
- R7: The byte being shifted out is captured from `regRdata` at the byte boundary. A change of the register during the byte does not alter the bits still to be sent.
- R8: `regWe` is never high on two consecutive clock cycles.
- R9: A seven-byte burst starting at address 0x01 covers registers 0x01 through 0x07 in order, both for reads and for writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, which oversamples the serial lines |
| rstN | input | 1 | Asynchronous reset, active low |
| sck | input | 1 | Serial clock from the host, idle low |
| csN | input | 1 | Chip select from the host, active low |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host; 0 outside a read data phase |
| regAddr | output | ADDR_W | Register address toward the clock register file |
| regWdata | output | WORD_W | Write data toward the register file |
| regWe | output | 1 | One-cycle write strobe |
| regRdata | input | WORD_W | Combinational read data for `regAddr` |

## Verification
A rising serial-clock edge from the host reaches the shifter on the second system-clock edge after it. A finished data byte therefore produces `regWe` on the fourth edge after the host's eighth rising edge, and the address moves one edge later. The bench keeps a queue of the writes it expects and, on every falling system-clock edge, pops and compares one entry whenever the strobe is seen, so the check does not depend on the exact cycle. The read bits change on `miso` three edges after a falling serial clock, and the bench samples them half a serial period later, right before it raises the clock. It compares whole bytes against its own model of the register file, and it checks on every cycle that the outputs are quiet once chip select has been high for a while.

// File: rtl/spi_rtc_pkg.sv
package spi_rtc_pkg;

  // serial word size
  localparam int WORD_W = 8;

  // instruction bytes acted upon; all others are absorbed
  localparam logic [WORD_W-1:0] OP_CLK_RD = 8'h13;
  localparam logic [WORD_W-1:0] OP_CLK_WR = 8'h12;

  typedef enum logic [2:0] {
    PH_OPCODE,
    PH_ADDR,
    PH_WRITE,
    PH_READ,
    PH_SKIP
  } phase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadAddr;     // address byte just completed
    logic writeByte;    // write data byte just completed
    logic readAdvance;  // read data byte just completed
    logic readActive;   // read data phase in progress
  } ctrl_strb_t;

endpackage

// File: rtl/spi_rtc_datapath.sv
module spi_rtc_datapath
  import spi_rtc_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int LAST_ADDR   = 31,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sck,
  input  logic              csN,
  input  logic              mosi,
  input  ctrl_strb_t        strb,
  input  logic [WORD_W-1:0] regRdata,
  output logic              csActive,
  output logic              byteDone,
  output logic [WORD_W-1:0] rxByte,
  output logic [ADDR_W-1:0] regAddr,
  output logic [WORD_W-1:0] regWdata,
  output logic              regWe,
  output logic              miso
);

  localparam int BIT_W = $clog2(WORD_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);
  localparam logic [ADDR_W-1:0] TOP_ADDR = ADDR_W'(LAST_ADDR);

  logic [SYNC_STAGES-1:0] sckPipe;
  logic [SYNC_STAGES-1:0] csPipe;
  logic [SYNC_STAGES-1:0] mosiPipe;
  logic                   sckLast;
  logic                   sckSync;
  logic                   mosiSync;
  logic                   sckRise;
  logic                   sckFall;
  logic [BIT_W-1:0]       bitCnt;
  logic [WORD_W-1:0]      rxShift;
  logic [WORD_W-1:0]      txShift;
  logic [ADDR_W-1:0]      addrQ;
  logic [ADDR_W-1:0]      addrNext;

  // input synchronisers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckPipe  <= '0;
      csPipe   <= '1;
      mosiPipe <= '0;
      sckLast  <= 1'b0;
    end else begin
      sckPipe  <= {sckPipe[SYNC_STAGES-2:0], sck};
      csPipe   <= {csPipe[SYNC_STAGES-2:0], csN};
      mosiPipe <= {mosiPipe[SYNC_STAGES-2:0], mosi};
      sckLast  <= sckSync;
    end
  end

  assign sckSync  = sckPipe[SYNC_STAGES-1];
  assign mosiSync = mosiPipe[SYNC_STAGES-1];
  assign csActive = ~csPipe[SYNC_STAGES-1];
  assign sckRise  = csActive & sckSync & ~sckLast;
  assign sckFall  = csActive & ~sckSync & sckLast;

  // receive shifter and bit counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt   <= '0;
      rxShift  <= '0;
      byteDone <= 1'b0;
    end else begin
      byteDone <= sckRise && (bitCnt == LAST_BIT);
      if (!csActive) begin
        bitCnt <= '0;
      end else if (sckRise) begin
        bitCnt  <= bitCnt + 1'b1;
        rxShift <= {rxShift[WORD_W-2:0], mosiSync};
      end
    end
  end

  assign rxByte = rxShift;

  // transmit shifter: captured at the byte boundary, shifted on falling edges
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
    end else if (!csActive) begin
      txShift <= '0;
    end else if (sckFall && strb.readActive) begin
      if (bitCnt == '0) txShift <= regRdata;
      else              txShift <= {txShift[WORD_W-2:0], 1'b0};
    end
  end

  assign miso = strb.readActive & txShift[WORD_W-1];

  // address register with wrap
  assign addrNext = (addrQ >= TOP_ADDR) ? '0 : addrQ + 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ    <= '0;
      regWe    <= 1'b0;
      regWdata <= '0;
    end else begin
      regWe <= strb.writeByte;
      if (strb.writeByte) regWdata <= rxByte;
      if (strb.loadAddr)         addrQ <= ADDR_W'(rxByte);
      else if (regWe)            addrQ <= addrNext;
      else if (strb.readAdvance) addrQ <= addrNext;
    end
  end

  assign regAddr = addrQ;

endmodule

// File: rtl/spi_rtc_control.sv
module spi_rtc_control
  import spi_rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              csActive,
  input  logic              byteDone,
  input  logic [WORD_W-1:0] rxByte,
  output ctrl_strb_t        strb
);

  phase_e phase;
  logic   isRead;
  logic   byteIn;

  assign byteIn = byteDone & csActive;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase  <= PH_OPCODE;
      isRead <= 1'b0;
    end else if (!csActive) begin
      phase  <= PH_OPCODE;
      isRead <= 1'b0;
    end else if (byteIn) begin
      unique case (phase)
        PH_OPCODE: begin
          if (rxByte == OP_CLK_RD) begin
            phase  <= PH_ADDR;
            isRead <= 1'b1;
          end else if (rxByte == OP_CLK_WR) begin
            phase  <= PH_ADDR;
            isRead <= 1'b0;
          end else begin
            phase <= PH_SKIP;
          end
        end
        PH_ADDR:  phase <= isRead ? PH_READ : PH_WRITE;
        PH_WRITE: phase <= PH_WRITE;
        PH_READ:  phase <= PH_READ;
        default:  phase <= PH_SKIP;
      endcase
    end
  end

  always_comb begin
    strb.loadAddr    = byteIn && (phase == PH_ADDR);
    strb.writeByte   = byteIn && (phase == PH_WRITE);
    strb.readAdvance = byteIn && (phase == PH_READ);
    strb.readActive  = csActive && (phase == PH_READ);
  end

endmodule

// File: rtl/spi_rtc_slave.sv
module spi_rtc_slave
  import spi_rtc_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int LAST_ADDR   = 31,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sck,
  input  logic              csN,
  input  logic              mosi,
  output logic              miso,
  output logic [ADDR_W-1:0] regAddr,
  output logic [WORD_W-1:0] regWdata,
  output logic              regWe,
  input  logic [WORD_W-1:0] regRdata
);

  ctrl_strb_t        strb;
  logic              csActive;
  logic              byteDone;
  logic [WORD_W-1:0] rxByte;

  spi_rtc_control u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .csActive (csActive),
    .byteDone (byteDone),
    .rxByte   (rxByte),
    .strb     (strb)
  );

  spi_rtc_datapath #(
    .ADDR_W      (ADDR_W),
    .LAST_ADDR   (LAST_ADDR),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .sck      (sck),
    .csN      (csN),
    .mosi     (mosi),
    .strb     (strb),
    .regRdata (regRdata),
    .csActive (csActive),
    .byteDone (byteDone),
    .rxByte   (rxByte),
    .regAddr  (regAddr),
    .regWdata (regWdata),
    .regWe    (regWe),
    .miso     (miso)
  );

endmodule

// File: rtl/spi_rtc_slave_chk.sv
module spi_rtc_slave_chk #(
  parameter int ADDR_W    = 8,
  parameter int LAST_ADDR = 31
) (
  input logic              clk,
  input logic              rstN,
  input logic              sck,
  input logic              csN,
  input logic              miso,
  input logic              regWe,
  input logic [ADDR_W-1:0] regAddr
);

  localparam logic [ADDR_W-1:0] TOP_ADDR = ADDR_W'(LAST_ADDR);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (csN && $past(csN) && $past(csN, 2) && $past(csN, 3)) |-> (!miso && !regWe));

  // R8
  single_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    regWe |=> !regWe);

  // R4
  addr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    regWe |=> (regAddr == (($past(regAddr) >= TOP_ADDR) ? '0 : $past(regAddr) + 1'b1)));

  // R3
  strobe_in_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    regWe |-> !csN);

  // R2
  miso_steady_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && !$past(csN) && sck && $past(sck)) |-> $stable(miso));

endmodule

bind spi_rtc_slave spi_rtc_slave_chk #(
  .ADDR_W    (ADDR_W),
  .LAST_ADDR (LAST_ADDR)
) chk (
  .clk     (clk),
  .rstN    (rstN),
  .sck     (sck),
  .csN     (csN),
  .miso    (miso),
  .regWe   (regWe),
  .regAddr (regAddr)
);

// File: tb/spi_rtc_slave_test.sv
module spi_rtc_slave_test;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;
  localparam int LAST       = 31;

  logic       clk  = 1'b0;
  logic       rstN = 1'b0;
  logic       sck  = 1'b0;
  logic       csN  = 1'b1;
  logic       mosi = 1'b0;
  logic       miso;
  logic [7:0] regAddr;
  logic [7:0] regWdata;
  logic       regWe;
  logic [7:0] regRdata;

  logic [7:0]  mem [0:255];
  logic [15:0] expQ [$];
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  assign regRdata = mem[regAddr];

  spi_rtc_slave #(.ADDR_W(8), .LAST_ADDR(LAST)) uut (
    .clk(clk), .rstN(rstN), .sck(sck), .csN(csN), .mosi(mosi),
    .miso(miso), .regAddr(regAddr), .regWdata(regWdata),
    .regWe(regWe), .regRdata(regRdata)
  );

  function automatic logic [7:0] nextA(input logic [7:0] a);
    return (a >= 8'(LAST)) ? 8'h00 : a + 8'h01;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic spiBits(input logic [7:0] tx, input int n, output logic [7:0] rx);
    rx = '0;
    for (int i = 0; i < n; i++) begin
      mosi = tx[7-i];
      waitClk(HALF);
      rx = {rx[6:0], miso};
      sck = 1'b1;
      waitClk(HALF);
      sck = 1'b0;
    end
  endtask

  task automatic csStart();
    csN = 1'b0;
    waitClk(HALF);
  endtask

  task automatic csEnd();
    waitClk(HALF);
    csN = 1'b1;
    waitClk(2 * HALF);
  endtask

  task automatic writeBurst(input logic [7:0] a, input logic [7:0] d[$], input string req);
    logic [7:0] rx;
    logic [7:0] p;
    p = a;
    foreach (d[i]) begin
      expQ.push_back({p, d[i]});
      p = nextA(p);
    end
    csStart();
    spiBits(8'h12, 8, rx);
    spiBits(a, 8, rx);
    foreach (d[i]) spiBits(d[i], 8, rx);
    csEnd();
    check(expQ.size() == 0, req, "writes left pending", expQ.size(), 0);
  endtask

  task automatic readBurst(input logic [7:0] a, input int n, input string req);
    logic [7:0] rx;
    logic [7:0] p;
    logic [7:0] exp [$];
    p = a;
    for (int i = 0; i < n; i++) begin
      exp.push_back(mem[p]);
      p = nextA(p);
    end
    csStart();
    spiBits(8'h13, 8, rx);
    spiBits(a, 8, rx);
    for (int i = 0; i < n; i++) begin
      spiBits(8'h00, 8, rx);
      check(rx == exp[i], req, $sformatf("read byte %0d from %0h", i, a), rx, exp[i]);
    end
    csEnd();
  endtask

  initial begin
    logic [7:0] rx;
    logic [7:0] r1;
    logic [7:0] r2;
    logic [7:0] old;
    logic [7:0] snap [0:7];
    logic [7:0] ign [11];
    ign = '{8'h03, 8'h02, 8'h04, 8'h06, 8'h05, 8'h01, 8'h14, 8'h32, 8'h33, 8'h44, 8'h54};

    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);

    fork
      // monitor and reference register file, every clock
      begin
        int  idleCnt = 0;
        bit  weLast  = 1'b0;
        logic [15:0] e;
        forever begin
          @(negedge clk);
          if (rstN) begin
            idleCnt = csN ? idleCnt + 1 : 0;
            if (idleCnt > 6)
              check(!miso && !regWe, "R1", "idle outputs", {miso, regWe}, 0);
            if (regWe) begin
              check(!weLast, "R8", "strobe on consecutive cycles", 1, 0);
              if (expQ.size() == 0) begin
                check(1'b0, "R5", "unexpected write strobe", regAddr, 0);
              end else begin
                e = expQ.pop_front();
                check(regAddr == e[15:8], "R4", "write address", regAddr, e[15:8]);
                check(regWdata == e[7:0], "R3", "write data", regWdata, e[7:0]);
              end
              mem[regAddr] = regWdata;
            end
            weLast = regWe;
          end
        end
      end
      // watchdog
      begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    join_none

    // reset state, R1
    waitClk(5);
    check(miso == 1'b0, "R1", "miso in reset", miso, 0);
    check(regWe == 1'b0, "R1", "regWe in reset", regWe, 0);
    rstN = 1'b1;
    waitClk(10);
    check(miso == 1'b0 && regWe == 1'b0, "R1", "idle after reset", {miso, regWe}, 0);

    // R9 seven-byte write and read from 0x01
    writeBurst(8'h01, '{8'h45, 8'h30, 8'h12, 8'h03, 8'h21, 8'h07, 8'h24}, "R9");
    readBurst(8'h01, 7, "R9");
    check(mem[7] == 8'h24, "R9", "year register", mem[7], 8'h24);

    // R2 single and mixed-pattern reads
    readBurst(8'h10, 1, "R2");
    writeBurst(8'h12, '{8'hFF, 8'h00, 8'hAA, 8'h55}, "R3");
    readBurst(8'h12, 4, "R2");

    // R4 wrap on write and read
    writeBurst(8'h1E, '{8'hC1, 8'hC2, 8'hC3}, "R4");
    check(mem[0] == 8'hC3, "R4", "wrapped write to 0x00", mem[0], 8'hC3);
    readBurst(8'h1F, 3, "R4");

    // R5 absorbed instructions
    for (int i = 0; i < 8; i++) snap[i] = mem[i];
    foreach (ign[k]) begin
      csStart();
      spiBits(ign[k], 8, rx);
      spiBits(8'h01, 8, rx);
      spiBits(8'hA5, 8, rx);
      check(rx == 8'h00, "R5", $sformatf("miso under op %0h", ign[k]), rx, 0);
      spiBits(8'h5A, 8, rx);
      check(rx == 8'h00, "R5", $sformatf("miso under op %0h", ign[k]), rx, 0);
      csEnd();
    end
    check(expQ.size() == 0, "R5", "no writes from absorbed ops", expQ.size(), 0);
    readBurst(8'h00, 8, "R5");
    for (int i = 0; i < 8; i++)
      check(mem[i] == snap[i], "R5", $sformatf("register %0d kept", i), mem[i], snap[i]);

    // R6 partial byte discarded at release
    expQ.push_back({8'h08, 8'h5A});
    csStart();
    spiBits(8'h12, 8, rx);
    spiBits(8'h08, 8, rx);
    spiBits(8'h5A, 8, rx);
    spiBits(8'hFF, 5, rx);
    csEnd();
    check(expQ.size() == 0, "R6", "only complete byte written", expQ.size(), 0);
    check(mem[8] == 8'h5A && mem[9] == 8'(9 * 7 + 3), "R6", "partial byte dropped",
          {mem[8], mem[9]}, {8'h5A, 8'(9 * 7 + 3)});

    // R6 abort inside the instruction byte, then a clean frame
    csStart();
    spiBits(8'h12, 4, rx);
    csEnd();
    check(expQ.size() == 0, "R6", "aborted opcode", expQ.size(), 0);
    writeBurst(8'h0A, '{8'h9C}, "R6");
    check(mem[10] == 8'h9C, "R6", "frame after abort", mem[10], 8'h9C);

    // R7 register change mid-byte does not disturb shifted bits
    csStart();
    spiBits(8'h13, 8, rx);
    spiBits(8'h05, 8, rx);
    old = mem[5];
    spiBits(8'h00, 3, r1);
    mem[5] = ~old;
    spiBits(8'h00, 5, r2);
    rx = {r1[2:0], r2[4:0]};
    check(rx == old, "R7", "byte captured at boundary", rx, old);
    csEnd();

    waitClk(20);
    check(expQ.size() == 0, "R3", "final write queue", expQ.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule